// File: doc/BRIEF.md
# Multiply-Pipe Issue Interlock Scoreboard

This block decides, every cycle, whether the instruction at the head of an in-order SIMD coprocessor issue stage may go. The coprocessor has three pipes: a multiply-accumulate pipe, a memory pipe and a general execution pipe. Next to it runs a host integer core. A decoder presents one instruction per cycle with its class, its destination register and up to three source registers, each with a valid bit. The block raises `stall` when the instruction would find its pipe still occupied, or when it would read a register whose result has not yet been produced.

Each class carries three latencies of its own. The issue latency is always one cycle. The resource latency sets how long the pipe stays occupied. The result latency sets how long until the destination can be read. Because these are kept apart, a load or an execution-pipe operation with no register dependency goes straight through underneath a two-cycle multiply. A host integer instruction is never held by coprocessor state. The block does no operand fetch, no arithmetic and no memory access. It also leaves host-side hazards to the host.

Top module: `ilk_scoreboard`

## Requirements
- R1: After reset is released, every register and every pipe counts as free, so the first instruction of any class issues with `stall` low.
- R2: The class codes are 0 host, 1 execution, 2 load, 3 SIMD multiply-accumulate, 4 tile multiply-accumulate. Two tile multiply-accumulates on consecutive cycles stall the second for exactly one cycle, because the multiply pipe has a resource latency of 2.
- R3: An execution-pipe instruction that reads the destination of the tile multiply-accumulate issued one cycle before stalls for exactly one cycle, because of the result latency of 2.
- R4: A SIMD multiply-accumulate occupies the multiply pipe for 2 cycles. Any multiply-class instruction that follows it on the next cycle stalls for exactly one cycle.
- R5: A load (memory pipe, resource latency 1) or an execution-pipe instruction (resource latency 1) with no register dependency issues without a stall right after either multiply-accumulate class.
- R6: A host instruction (code 0), and any unused class code 5 to 7, never stalls and leaves the scoreboard untouched, whatever registers it names.
- R7: A source slot whose valid bit is set stalls the instruction until the named register's result latency has elapsed since its producer issued. The result latencies are load 3, execution 1, and 2 for both multiply classes. A dependent execution instruction directly after a load therefore stalls 2 cycles, and one directly after another execution instruction does not stall.
- R8: A stalled instruction changes no scoreboard state, while all countdowns keep moving. If the stalled instruction is withdrawn, no later instruction waits on it.
- R9: Both multiply-accumulate classes read their own destination as the accumulator. They wait for a pending result in that register even when no source slot is valid.
- R10: A source slot whose valid bit (`in_src_vld` bit i for source i) is clear never causes a stall.
- R11: With `in_valid` low, `stall` is low and the scoreboard is not updated, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_cls | input | 3 | Instruction class code (see R2) |
| in_dst | input | RW (4) | Destination register |
| in_src0 | input | RW (4) | Source register 0 |
| in_src1 | input | RW (4) | Source register 1 |
| in_src2 | input | RW (4) | Source register 2 |
| in_src_vld | input | 3 | Valid bit for each source slot |
| stall | output | 1 | Hold the presented instruction this cycle |

## Verification
`stall` is combinational from the presented instruction and the registered countdowns. The verdict for an instruction is therefore due in the same cycle it is presented. An instruction that issues at clock edge t affects instructions presented from cycle t+1, until its resource or result latency has run out. The bench drives inputs on the falling edge, reads `stall` shortly afterwards in that same cycle, and only then lets the rising edge commit. Its model records, for each pipe and register, the absolute cycle from which it becomes free. Directed cases count the stall cycles an instruction suffers before it goes, and random traffic compares every cycle against the model.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    CLS_HOST = 3'd0,
    CLS_EXEC = 3'd1,
    CLS_LOAD = 3'd2,
    CLS_SMAC = 3'd3,
    CLS_TMAC = 3'd4
  } ilk_cls_e;

  localparam int NPIPE    = 3;
  localparam int PIPE_MUL = 0;
  localparam int PIPE_MEM = 1;
  localparam int PIPE_EXE = 2;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ilk_countdown.sv
module ilk_countdown #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic          busy
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = ld | (cnt_q != '0);
    if (ld) cnt_d = ld_val;
    else    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  AST_CNT_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
  AST_CNT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cnt_q == '0) |=> (cnt_q == '0)); // R11

endmodule

// File: rtl/ilk_pipe_board.sv
module ilk_pipe_board #(
  parameter int NP = 3,
  parameter int PW = 2,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [PW-1:0] take_pipe,
  input  logic [CW-1:0] take_lat,
  output logic [NP-1:0] pipe_busy
);

  for (genvar p = 0; p < NP; p++) begin : g_pipe
    logic ld_p;
    assign ld_p = take && (take_pipe == PW'(p));
    ilk_countdown #(.CW(CW)) u_cd (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (ld_p),
      .ld_val (take_lat),
      .busy   (pipe_busy[p])
    );
  end

endmodule

// File: rtl/ilk_reg_board.sv
module ilk_reg_board #(
  parameter int NREG = 16,
  parameter int RW   = 4,
  parameter int CW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_idx,
  input  logic [CW-1:0]   wr_lat,
  output logic [NREG-1:0] reg_pend
);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic ld_r;
    assign ld_r = wr_en && (wr_idx == RW'(r));
    ilk_countdown #(.CW(CW)) u_cd (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (ld_r),
      .ld_val (wr_lat),
      .busy   (reg_pend[r])
    );
  end

endmodule

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard
  import ilk_pkg::*;
#(
  parameter int NREG      = 16,
  parameter int RW        = $clog2(NREG),
  parameter int MUL_RES   = 2,
  parameter int MEM_RES   = 1,
  parameter int EXE_RES   = 1,
  parameter int TMAC_RSLT = 2,
  parameter int SMAC_RSLT = 2,
  parameter int LOAD_RSLT = 3,
  parameter int EXEC_RSLT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    in_cls,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_src0,
  input  logic [RW-1:0] in_src1,
  input  logic [RW-1:0] in_src2,
  input  logic [2:0]    in_src_vld,
  output logic          stall
);

  localparam int MAXLAT = imax(imax(imax(MUL_RES, MEM_RES), imax(EXE_RES, TMAC_RSLT)),
                               imax(SMAC_RSLT, imax(LOAD_RSLT, EXEC_RSLT)));
  localparam int CW = $clog2(MAXLAT + 1);
  localparam int PW = $clog2(NPIPE);

  ilk_cls_e        cls;
  logic            is_cop;
  logic            is_mac;
  logic [PW-1:0]   pipe_sel;
  logic [CW-1:0]   res_ld;
  logic [CW-1:0]   rslt_ld;
  logic [NPIPE-1:0] pipe_busy;
  logic [NREG-1:0] reg_pend;
  logic            src_hit;
  logic            acc_hit;
  logic            res_hit;
  logic            issue;

  // class decode: pipe and the countdown values to load (latency minus the issue cycle)
  always_comb begin
    cls      = ilk_cls_e'(in_cls);
    is_cop   = 1'b1;
    is_mac   = 1'b0;
    pipe_sel = PW'(PIPE_EXE);
    res_ld   = CW'(EXE_RES - 1);
    rslt_ld  = CW'(EXEC_RSLT - 1);
    case (cls)
      CLS_EXEC: begin
        pipe_sel = PW'(PIPE_EXE);
        res_ld   = CW'(EXE_RES - 1);
        rslt_ld  = CW'(EXEC_RSLT - 1);
      end
      CLS_LOAD: begin
        pipe_sel = PW'(PIPE_MEM);
        res_ld   = CW'(MEM_RES - 1);
        rslt_ld  = CW'(LOAD_RSLT - 1);
      end
      CLS_SMAC: begin
        is_mac   = 1'b1;
        pipe_sel = PW'(PIPE_MUL);
        res_ld   = CW'(MUL_RES - 1);
        rslt_ld  = CW'(SMAC_RSLT - 1);
      end
      CLS_TMAC: begin
        is_mac   = 1'b1;
        pipe_sel = PW'(PIPE_MUL);
        res_ld   = CW'(MUL_RES - 1);
        rslt_ld  = CW'(TMAC_RSLT - 1);
      end
      default: is_cop = 1'b0;
    endcase
  end

  // hazard detection
  always_comb begin
    src_hit = (in_src_vld[0] && reg_pend[in_src0]) ||
              (in_src_vld[1] && reg_pend[in_src1]) ||
              (in_src_vld[2] && reg_pend[in_src2]);
    acc_hit = is_mac && reg_pend[in_dst];
    res_hit = pipe_busy[pipe_sel];
    stall   = in_valid && is_cop && (src_hit || acc_hit || res_hit);
    issue   = in_valid && is_cop && !stall;
  end

  ilk_pipe_board #(.NP(NPIPE), .PW(PW), .CW(CW)) u_pipes (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (issue),
    .take_pipe (pipe_sel),
    .take_lat  (res_ld),
    .pipe_busy (pipe_busy)
  );

  ilk_reg_board #(.NREG(NREG), .RW(RW), .CW(CW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (issue),
    .wr_idx   (in_dst),
    .wr_lat   (rslt_ld),
    .reg_pend (reg_pend)
  );

  AST_HOST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(in_cls inside {3'd1, 3'd2, 3'd3, 3'd4})) |-> !stall); // R6
  AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !stall); // R11
  AST_SRC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_src_vld == 3'b000 && !is_mac && !pipe_busy[pipe_sel]) |-> !stall); // R10

  if (MUL_RES >= 2) begin : g_mul_chk
    AST_MUL_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && is_mac) |=> (!(in_valid && in_cls inside {3'd3, 3'd4}) || stall)); // R4
  end

  if (TMAC_RSLT >= 2) begin : g_rslt_chk
    AST_TMAC_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && cls == CLS_TMAC) |=>
        (!(in_valid && in_cls == 3'd1 && in_src_vld[0] && in_src0 == $past(in_dst)) || stall)); // R3
  end

endmodule

// File: tb/ilk_scoreboard_tb_top.sv
module ilk_scoreboard_tb_top;

  localparam int NREG = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [2:0] in_cls;
  logic [3:0] in_dst, in_src0, in_src1, in_src2;
  logic [2:0] in_src_vld;
  logic       stall;

  always #5 clk = ~clk;

  ilk_scoreboard dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
    .in_dst(in_dst), .in_src0(in_src0), .in_src1(in_src1), .in_src2(in_src2),
    .in_src_vld(in_src_vld), .stall(stall)
  );

  int checks = 0;
  int errs   = 0;
  int cyc_n  = 0;
  int reg_rdy [NREG];
  int pipe_free [3];
  bit done = 1'b0;

  // model: absolute cycle from which each resource is free
  function automatic int pipe_of(input int c);
    case (c)
      1: return 2;
      2: return 1;
      3, 4: return 0;
      default: return -1;
    endcase
  endfunction
  function automatic int res_of(input int c);
    return (c == 3 || c == 4) ? 2 : 1;
  endfunction
  function automatic int rslt_of(input int c);
    case (c)
      2: return 3;
      3, 4: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic bit model_stall();
    int p;
    p = pipe_of(int'(in_cls));
    if (!in_valid || p < 0) return 1'b0;
    if (cyc_n < pipe_free[p]) return 1'b1;
    if (in_src_vld[0] && cyc_n < reg_rdy[in_src0]) return 1'b1;
    if (in_src_vld[1] && cyc_n < reg_rdy[in_src1]) return 1'b1;
    if (in_src_vld[2] && cyc_n < reg_rdy[in_src2]) return 1'b1;
    if ((in_cls == 3'd3 || in_cls == 3'd4) && cyc_n < reg_rdy[in_dst]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s cycle %0d: stall=%b expected %b", req, cyc_n, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: stall cycles=%0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int c, input int d,
                       input int s0, input int s1, input int s2, input int sv);
    in_valid   = v;
    in_cls     = 3'(c);
    in_dst     = 4'(d);
    in_src0    = 4'(s0);
    in_src1    = 4'(s1);
    in_src2    = 4'(s2);
    in_src_vld = 3'(sv);
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic tick(input string req, output bit st);
    bit exp;
    int p;
    #2;
    exp = model_stall();
    chk_bit(req, stall, exp);
    st = stall;
    p  = pipe_of(int'(in_cls));
    @(posedge clk);
    if (in_valid && p >= 0 && !exp) begin
      pipe_free[p] = cyc_n + res_of(int'(in_cls));
      reg_rdy[in_dst] = cyc_n + rslt_of(int'(in_cls));
    end
    cyc_n++;
    @(negedge clk);
  endtask

  // present and hold until issue; returns number of stall cycles
  task automatic go(input string req, input int c, input int d, input int s0,
                    input int s1, input int s2, input int sv, output int n);
    bit st;
    n = 0;
    drive(1'b1, c, d, s0, s1, s2, sv);
    for (int k = 0; k < 8; k++) begin
      tick(req, st);
      if (!st) break;
      n++;
    end
  endtask

  task automatic idle(input int k);
    bit st;
    drive(1'b0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < k; i++) tick("R11", st);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int n;
    bit st;
    void'($urandom(32'd1234));
    for (int i = 0; i < NREG; i++) reg_rdy[i] = 0;
    for (int i = 0; i < 3; i++) pipe_free[i] = 0;
    drive(1'b0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: first instruction after reset
    go("R1", 4, 0, 1, 2, 3, 7, n);      chk_int("R1", n, 0);
    idle(4);
    // R2: back-to-back tile MACs
    go("R2", 4, 0, 1, 1, 1, 0, n);      chk_int("R2", n, 0);
    go("R2", 4, 1, 2, 2, 2, 0, n);      chk_int("R2", n, 1);
    idle(4);
    // R3: dependent exec after tile MAC
    go("R3", 4, 2, 5, 5, 5, 0, n);
    go("R3", 1, 3, 2, 0, 0, 1, n);      chk_int("R3", n, 1);
    idle(4);
    // R4: SIMD MAC holds multiply pipe
    go("R4", 3, 4, 1, 1, 1, 0, n);
    go("R4", 3, 5, 6, 6, 6, 1, n);      chk_int("R4", n, 1);
    idle(4);
    go("R4", 3, 4, 1, 1, 1, 0, n);
    go("R4", 4, 6, 7, 7, 7, 1, n);      chk_int("R4", n, 1);
    idle(4);
    // R5: load and exec slip under a MAC
    go("R5", 3, 4, 1, 1, 1, 0, n);
    go("R5", 2, 7, 8, 8, 8, 1, n);      chk_int("R5", n, 0);
    go("R5", 1, 9, 10, 11, 12, 7, n);   chk_int("R5", n, 0);
    idle(4);
    go("R5", 4, 0, 1, 1, 1, 0, n);
    go("R5", 1, 9, 10, 10, 10, 1, n);   chk_int("R5", n, 0);
    idle(4);
    // R6: host and unused codes never stall, never update
    go("R6", 3, 4, 1, 1, 1, 0, n);
    go("R6", 0, 4, 4, 4, 4, 7, n);      chk_int("R6", n, 0);
    go("R6", 7, 8, 4, 4, 4, 7, n);      chk_int("R6", n, 0);
    go("R6", 1, 9, 8, 8, 8, 1, n);      chk_int("R6", n, 0);
    idle(4);
    // R7: load result latency 3, exec result latency 1
    go("R7", 2, 11, 0, 0, 0, 0, n);
    go("R7", 1, 12, 0, 11, 0, 2, n);    chk_int("R7", n, 2);
    go("R7", 1, 13, 0, 0, 12, 4, n);    chk_int("R7", n, 0);
    idle(4);
    // R8: stalled instruction withdrawn leaves no trace
    go("R8", 4, 0, 1, 1, 1, 0, n);
    drive(1'b1, 4, 5, 1, 1, 1, 0);
    tick("R8", st);                     chk_bit("R8", st, 1'b1);
    go("R8", 1, 9, 5, 5, 5, 1, n);      chk_int("R8", n, 0);
    idle(4);
    // R8: the held one updates only when it issues
    go("R8", 4, 0, 1, 1, 1, 0, n);
    go("R8", 4, 6, 1, 1, 1, 0, n);      chk_int("R8", n, 1);
    go("R8", 1, 9, 6, 6, 6, 1, n);      chk_int("R8", n, 1);
    idle(4);
    // R9: accumulator read of own destination
    go("R9", 2, 13, 0, 0, 0, 0, n);
    go("R9", 3, 13, 0, 0, 0, 0, n);     chk_int("R9", n, 2);
    idle(4);
    // R10: invalid source slot ignored
    go("R10", 4, 0, 1, 1, 1, 0, n);
    go("R10", 1, 9, 0, 0, 0, 0, n);     chk_int("R10", n, 0);
    idle(4);
    // R11: invalid slot with pending fields, then no update
    go("R11", 4, 0, 1, 1, 1, 0, n);
    drive(1'b0, 4, 0, 0, 0, 0, 7);
    tick("R11", st);                    chk_bit("R11", st, 1'b0);
    idle(4);
    drive(1'b0, 2, 14, 0, 0, 0, 0);
    tick("R11", st);
    go("R11", 1, 9, 14, 14, 14, 7, n);  chk_int("R11", n, 0);
    idle(4);

    // random traffic against the model (R7 and the rest)
    drive(1'b0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      if (!(in_valid && stall)) begin
        int r;
        r = int'($urandom_range(0, 19));
        drive(r != 0, (r > 17) ? int'($urandom_range(5, 7)) : int'($urandom_range(0, 4)),
              int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 7)));
      end
      tick("R7", st);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule